// File: doc/BRIEF.md
# Interrupt Flag and Enable Unit for a Stand-alone Bus Controller

This unit holds the interrupt enable mask and the interrupt flag register of a stand-alone CAN controller. The protocol core delivers one-cycle event pulses: bus error, arbitration lost, error-passive change, data overrun, error-warning change and transmit done. It also delivers a level that says whether the receive FIFO holds a message. The CPU side has one small register port. Address `cpu_sel=1` is the read/write enable mask and address `cpu_sel=0` is the read-only flag register. Reading the flag register acknowledges the latched sources. A single active-low line signals the CPU while any flag is set.

Two behaviours set this unit apart from a plain sticky register. The receive flag follows FIFO occupancy and is not acknowledged by a read. A release command drops the receive flag for one cycle, and the flag comes back only if another message is still waiting. A sleep request is refused while the bus is busy or while an interrupt is pending. Such a refusal, and any bus activity that ends a sleep, produce a wake-up event.

The design is built from three state machines:
- The receive tracker has states RX_EMPTY, RX_READY and RX_GAP. It moves EMPTY→READY on buffer full, READY→GAP on release, READY→EMPTY on buffer empty, GAP→READY if still full, and GAP→EMPTY otherwise.
- The power machine has states PW_RUN and PW_SLEEP. It moves RUN→SLEEP on a sleep request while idle with nothing pending, and SLEEP→RUN on bus activity.
- Each latched flag has a two-state machine with states FLG_IDLE and FLG_SET. It moves IDLE→SET on an enabled event, and SET→IDLE on a flag read with no enabled event in the same cycle.

Top module: `canc_irq_unit`

## Requirements
- R1: After reset the enable mask reads 0x00, the flag register reads 0x00, `irq_n` is 1 and `sleeping` is 0.
- R2: A write with `cpu_sel=1` loads the enable mask, and the mask reads back unchanged. A write with `cpu_sel=0` has no effect on the flag register.
- R3: The flag bits and mask bits share one layout: bit 7 bus error, bit 6 arbitration lost, bit 5 error-passive change, bit 4 wake-up, bit 3 data overrun, bit 2 error-warning change, bit 1 transmit done, bit 0 receive. An event on bits 7..1 whose mask bit is 1 at a clock edge sets its flag after that edge, and the flag stays set until the flag register is read.
- R4: An event whose mask bit is 0 does not set its flag. Clearing a mask bit does not clear a flag that is already latched.
- R5: A read of the flag register (`cpu_rd=1`, `cpu_sel=0`) clears flag bits 7..1 at that edge, except a bit whose enabled event arrives at the same edge. That bit stays set.
- R6: Flag bit 0 is 1 exactly when the tracker saw the buffer full at the previous edge and mask bit 0 is 1. A read of the flag register does not clear it.
- R7: A release while bit 0 is set clears bit 0 for one cycle. In the next cycle bit 0 is set again if the buffer is still full, and otherwise it stays cleared.
- R8: A sleep request while `bus_busy` is 0 and no flag is set makes `sleeping` 1 after the edge.
- R9: A sleep request while `bus_busy` is 1 or while any flag is set leaves `sleeping` at 0 and raises the wake-up event (flag bit 4 when enabled).
- R10: While sleeping, `bus_busy`=1 returns `sleeping` to 0 and raises the wake-up event.
- R11: `irq_n` is 0 exactly when at least one bit of the flag register is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 1 | Register select: 0 flag register, 1 enable mask |
| cpu_wr | input | 1 | Write strobe |
| cpu_rd | input | 1 | Read strobe (acknowledges flags when `cpu_sel`=0) |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data of the selected register |
| rxbuf_full | input | 1 | Receive FIFO holds at least one message |
| rx_release | input | 1 | Release-receive-buffer command pulse |
| ev_tx_done | input | 1 | Transmit done or transmit buffer free again |
| ev_warn_chg | input | 1 | Error or bus status changed |
| ev_overrun | input | 1 | Overrun status became set |
| ev_passive_chg | input | 1 | Error-active/error-passive change, either direction |
| ev_arb_lost | input | 1 | Arbitration lost |
| ev_bus_err | input | 1 | Bus error detected |
| bus_busy | input | 1 | Controller takes part in bus activity |
| sleep_req | input | 1 | CPU request to enter sleep |
| sleeping | output | 1 | Controller is in sleep mode |
| irq_n | output | 1 | Active-low interrupt to the CPU |

## Verification
The bench aims at a flag read that lands on the same edge as a fresh event. A design that clears first would lose that interrupt for good. It releases the receive buffer with the buffer still full and with it drained, which exposes a design that keeps the flag high through the release or that fails to set it again. It sends sleep requests while busy, while only the receive flag is pending, and while idle. A wrong entry condition would either put a busy controller to sleep or omit the wake-up flag. It also clears mask bits after a flag has latched, to catch a mask that wipes pending flags.

// File: rtl/canc_irq_pkg.sv
package canc_irq_pkg;

    // Shared bit layout of flag register and enable mask.
    localparam int IRQ_W    = 8;
    localparam int B_RX     = 0;
    localparam int B_TX     = 1;
    localparam int B_WARN   = 2;
    localparam int B_OVR    = 3;
    localparam int B_WAKE   = 4;
    localparam int B_PASS   = 5;
    localparam int B_ARB    = 6;
    localparam int B_BERR   = 7;

    typedef enum logic [1:0] {
        RX_EMPTY = 2'd0,
        RX_READY = 2'd1,
        RX_GAP   = 2'd2
    } rx_state_t;

    typedef enum logic {
        PW_RUN   = 1'b0,
        PW_SLEEP = 1'b1
    } pw_state_t;

    typedef enum logic {
        FLG_IDLE = 1'b0,
        FLG_SET  = 1'b1
    } flg_state_t;

endpackage

// File: rtl/canc_irq_latch.sv
module canc_irq_latch #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ev,
    input  logic [W-1:0] en,
    input  logic         clr,
    output logic [W-1:0] q
);
    import canc_irq_pkg::*;

    for (genvar i = 0; i < W; i++) begin : g_flag
        flg_state_t st_q;
        flg_state_t st_d;
        logic       hit;

        assign hit = ev[i] & en[i];

        always_ff @(posedge clk) begin
            if (!rst_n) st_q <= FLG_IDLE;
            else        st_q <= st_d;
        end

        always_comb begin
            st_d = st_q;
            unique case (st_q)
                FLG_IDLE: if (hit)         st_d = FLG_SET;
                FLG_SET:  if (clr && !hit) st_d = FLG_IDLE;
                default:                   st_d = FLG_IDLE;
            endcase
        end

        assign q[i] = (st_q == FLG_SET);

        // R3: a latched flag survives any cycle without a read
        p_flag_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (q[i] && !clr) |=> q[i]);

        // R4: a masked source cannot raise a clear flag
        p_masked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!q[i] && !en[i]) |=> !q[i]);
    end

endmodule

// File: rtl/canc_irq_rx.sv
module canc_irq_rx (
    input  logic clk,
    input  logic rst_n,
    input  logic buf_full,
    input  logic release_cmd,
    input  logic enable,
    output logic flag
);
    import canc_irq_pkg::*;

    rx_state_t st_q;
    rx_state_t st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RX_EMPTY;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RX_EMPTY: if (buf_full)    st_d = RX_READY;
            RX_READY: begin
                if (release_cmd)       st_d = RX_GAP;
                else if (!buf_full)    st_d = RX_EMPTY;
            end
            RX_GAP:   st_d = buf_full ? RX_READY : RX_EMPTY;
            default:                   st_d = RX_EMPTY;
        endcase
    end

    always_comb begin
        flag = (st_q == RX_READY) && enable;
    end

    // R7: the cycle after a release of a pending message shows no flag
    p_release_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RX_READY && release_cmd) |=> !flag);

    // R6: ready state is only reached with the buffer seen full
    p_ready_needs_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != RX_READY && st_d == RX_READY) |-> buf_full);

endmodule

// File: rtl/canc_irq_power.sv
module canc_irq_power (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic bus_busy,
    input  logic irq_pending,
    output logic sleeping,
    output logic wake_evt
);
    import canc_irq_pkg::*;

    pw_state_t st_q;
    pw_state_t st_d;
    logic      refuse;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= PW_RUN;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PW_RUN:   if (sleep_req && !bus_busy && !irq_pending) st_d = PW_SLEEP;
            PW_SLEEP: if (bus_busy)                               st_d = PW_RUN;
            default:                                              st_d = PW_RUN;
        endcase
    end

    always_comb begin
        refuse   = sleep_req && (bus_busy || irq_pending);
        sleeping = (st_q == PW_SLEEP);
        unique case (st_q)
            PW_RUN:   wake_evt = refuse;
            PW_SLEEP: wake_evt = bus_busy;
            default:  wake_evt = 1'b0;
        endcase
    end

    // R9: a busy controller never enters sleep
    p_busy_blocks_sleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleeping && bus_busy) |=> !sleeping);

    // R8: sleep is only entered from an idle request
    p_sleep_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleeping && !(sleep_req && !irq_pending)) |=> !sleeping);

endmodule

// File: rtl/canc_irq_unit.sv
module canc_irq_unit #(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_sel,
    input  logic             cpu_wr,
    input  logic             cpu_rd,
    input  logic [REG_W-1:0] cpu_wdata,
    output logic [REG_W-1:0] cpu_rdata,
    input  logic             rxbuf_full,
    input  logic             rx_release,
    input  logic             ev_tx_done,
    input  logic             ev_warn_chg,
    input  logic             ev_overrun,
    input  logic             ev_passive_chg,
    input  logic             ev_arb_lost,
    input  logic             ev_bus_err,
    input  logic             bus_busy,
    input  logic             sleep_req,
    output logic             sleeping,
    output logic             irq_n
);
    import canc_irq_pkg::*;

    localparam int LAT_W = REG_W - 1;

    logic [REG_W-1:0] mask_q;
    logic [REG_W-1:0] irq_vec;
    logic [REG_W-1:0] ev_vec;
    logic [LAT_W-1:0] lat_q;
    logic             rx_flag;
    logic             wake_evt;
    logic             flag_read;
    logic             mask_write;
    logic             pending;

    assign flag_read  = cpu_rd && !cpu_sel;
    assign mask_write = cpu_wr && cpu_sel;

    always_ff @(posedge clk) begin
        if (!rst_n)          mask_q <= '0;
        else if (mask_write) mask_q <= cpu_wdata;
    end

    always_comb begin
        ev_vec         = '0;
        ev_vec[B_TX]   = ev_tx_done;
        ev_vec[B_WARN] = ev_warn_chg;
        ev_vec[B_OVR]  = ev_overrun;
        ev_vec[B_WAKE] = wake_evt;
        ev_vec[B_PASS] = ev_passive_chg;
        ev_vec[B_ARB]  = ev_arb_lost;
        ev_vec[B_BERR] = ev_bus_err;
    end

    canc_irq_latch #(.W(LAT_W)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .ev    (ev_vec[REG_W-1:1]),
        .en    (mask_q[REG_W-1:1]),
        .clr   (flag_read),
        .q     (lat_q)
    );

    canc_irq_rx u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .buf_full    (rxbuf_full),
        .release_cmd (rx_release),
        .enable      (mask_q[B_RX]),
        .flag        (rx_flag)
    );

    canc_irq_power u_pwr (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_req   (sleep_req),
        .bus_busy    (bus_busy),
        .irq_pending (pending),
        .sleeping    (sleeping),
        .wake_evt    (wake_evt)
    );

    always_comb begin
        irq_vec       = {lat_q, rx_flag};
        pending       = |irq_vec;
        irq_n         = ~pending;
        cpu_rdata     = cpu_sel ? mask_q : irq_vec;
    end

    // R5: a read with no enabled event leaves bits 7..1 clear
    p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_read && ((ev_vec & mask_q) == '0)) |=> (irq_vec[REG_W-1:1] == '0));

    // R10: bus activity while asleep raises the enabled wake-up flag
    p_wake_on_activity_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sleeping && bus_busy && mask_q[B_WAKE]) |=> irq_vec[B_WAKE]);

    // R6: a read does not drop a receive flag whose buffer stays full
    p_read_keeps_rx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_read && irq_vec[B_RX] && rxbuf_full && !rx_release && !mask_write)
        |=> irq_vec[B_RX]);

endmodule

// File: tb/tb_canc_irq_unit.sv
module tb_canc_irq_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_sel = 1'b0, cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       rxbuf_full = 1'b0, rx_release = 1'b0;
    logic       ev_tx_done = 1'b0, ev_warn_chg = 1'b0, ev_overrun = 1'b0;
    logic       ev_passive_chg = 1'b0, ev_arb_lost = 1'b0, ev_bus_err = 1'b0;
    logic       bus_busy = 1'b0, sleep_req = 1'b0;
    logic       sleeping, irq_n;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    canc_irq_unit dut (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .rxbuf_full(rxbuf_full),
        .rx_release(rx_release), .ev_tx_done(ev_tx_done), .ev_warn_chg(ev_warn_chg),
        .ev_overrun(ev_overrun), .ev_passive_chg(ev_passive_chg),
        .ev_arb_lost(ev_arb_lost), .ev_bus_err(ev_bus_err), .bus_busy(bus_busy),
        .sleep_req(sleep_req), .sleeping(sleeping), .irq_n(irq_n)
    );

    // Reference model built from the requirements.
    logic [7:0] m_en = 8'h00;
    logic [7:1] m_lat = '0;
    int         m_rx = 0;      // 0 empty, 1 ready, 2 gap
    logic       m_sleep = 1'b0;

    function automatic logic [7:0] m_vec();
        return {m_lat, (m_rx == 1) && m_en[0]};
    endfunction

    function automatic logic m_wake();
        return m_sleep ? bus_busy : (sleep_req && (bus_busy || (m_vec() != 8'h00)));
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en <= 8'h00; m_lat <= '0; m_rx <= 0; m_sleep <= 1'b0;
        end else begin
            logic [7:1] evv;
            evv = {ev_bus_err, ev_arb_lost, ev_passive_chg, m_wake(),
                   ev_overrun, ev_warn_chg, ev_tx_done};
            m_lat <= ((cpu_rd && !cpu_sel) ? 7'h00 : m_lat) | (evv & m_en[7:1]);
            if (cpu_wr && cpu_sel) m_en <= cpu_wdata;
            case (m_rx)
                0: if (rxbuf_full) m_rx <= 1;
                1: if (rx_release) m_rx <= 2; else if (!rxbuf_full) m_rx <= 0;
                default: m_rx <= rxbuf_full ? 1 : 0;
            endcase
            if (!m_sleep) begin
                if (sleep_req && !bus_busy && (m_vec() == 8'h00)) m_sleep <= 1'b1;
            end else if (bus_busy) m_sleep <= 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic quiet();
        cpu_wr = 0; cpu_rd = 0; rx_release = 0; sleep_req = 0;
        ev_tx_done = 0; ev_warn_chg = 0; ev_overrun = 0;
        ev_passive_chg = 0; ev_arb_lost = 0; ev_bus_err = 0;
    endtask

    task automatic peek(input logic sel, input string tag, input logic [7:0] exp);
        cpu_sel = sel; #0.5;
        chk(tag, cpu_rdata, exp);
    endtask

    task automatic wr_mask(input logic [7:0] v);
        cpu_sel = 1; cpu_wr = 1; cpu_wdata = v; step(); quiet();
    endtask

    task automatic rd_flags();
        cpu_sel = 0; cpu_rd = 1; step(); quiet();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h1d5e_a7c3));
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        peek(1, "R1 mask", 8'h00);
        peek(0, "R1 flags", 8'h00);
        chk("R1 irq_n", irq_n, 1);
        chk("R1 sleeping", sleeping, 0);
        // R2 mask write and read-back; flag address ignores writes
        wr_mask(8'hFF);
        peek(1, "R2 mask readback", 8'hFF);
        cpu_sel = 0; cpu_wr = 1; cpu_wdata = 8'hFF; step(); quiet();
        peek(0, "R2 flag write ignored", 8'h00);
        // R3 event latching, R11 pin
        ev_tx_done = 1; step(); quiet();
        peek(0, "R3 tx flag", 8'h02);
        chk("R11 irq_n low", irq_n, 0);
        step();
        peek(0, "R3 tx flag held", 8'h02);
        rd_flags();
        peek(0, "R5 read clears", 8'h00);
        chk("R11 irq_n high", irq_n, 1);
        // R4 masked source and mask clear after latch
        wr_mask(8'h00);
        ev_bus_err = 1; step(); quiet();
        peek(0, "R4 masked event", 8'h00);
        wr_mask(8'hFF);
        ev_arb_lost = 1; step(); quiet();
        wr_mask(8'h00);
        peek(0, "R4 flag kept after mask clear", 8'h40);
        wr_mask(8'hFF);
        // R5 read with a same-edge event
        cpu_sel = 0; cpu_rd = 1; ev_overrun = 1; step(); quiet();
        peek(0, "R5 same-edge event kept", 8'h08);
        rd_flags();
        // R6 receive flag follows buffer and ignores reads
        rxbuf_full = 1; step();
        peek(0, "R6 rx flag", 8'h01);
        rd_flags();
        peek(0, "R6 rx survives read", 8'h01);
        // R7 release with another message waiting
        rx_release = 1; step(); quiet();
        peek(0, "R7 gap after release", 8'h00);
        step();
        peek(0, "R7 rx back", 8'h01);
        // R7 release with buffer drained
        rx_release = 1; step(); quiet(); rxbuf_full = 0;
        peek(0, "R7 gap drained", 8'h00);
        step();
        peek(0, "R7 stays clear", 8'h00);
        // R8 idle sleep, R10 wake on activity
        sleep_req = 1; step(); quiet();
        chk("R8 enters sleep", sleeping, 1);
        bus_busy = 1; step();
        chk("R10 wakes", sleeping, 0);
        peek(0, "R10 wake flag", 8'h10);
        rd_flags();
        // R9 refused while busy
        sleep_req = 1; step(); quiet();
        chk("R9 busy refuse", sleeping, 0);
        peek(0, "R9 busy wake flag", 8'h10);
        rd_flags(); bus_busy = 0;
        // R9 refused while a flag is pending
        rxbuf_full = 1; step();
        sleep_req = 1; step(); quiet();
        chk("R9 pending refuse", sleeping, 0);
        peek(0, "R9 pending wake flag", 8'h11);
        rxbuf_full = 0; rd_flags(); step();
        // Random phase against the model
        for (int c = 0; c < 4000; c++) begin
            cpu_sel = $urandom_range(0, 1);
            cpu_wr = ($urandom_range(0, 11) == 0);
            cpu_wdata = $urandom_range(0, 255) | $urandom_range(0, 255);
            cpu_rd = ($urandom_range(0, 5) == 0);
            rx_release = ($urandom_range(0, 7) == 0);
            sleep_req = ($urandom_range(0, 15) == 0);
            ev_tx_done = ($urandom_range(0, 9) == 0);
            ev_warn_chg = ($urandom_range(0, 13) == 0);
            ev_overrun = ($urandom_range(0, 13) == 0);
            ev_passive_chg = ($urandom_range(0, 13) == 0);
            ev_arb_lost = ($urandom_range(0, 11) == 0);
            ev_bus_err = ($urandom_range(0, 13) == 0);
            if ($urandom_range(0, 5) == 0) bus_busy = ~bus_busy;
            if ($urandom_range(0, 4) == 0) rxbuf_full = ~rxbuf_full;
            step();
            chk("R3 rdata", cpu_rdata, cpu_sel ? m_en : m_vec());
            chk("R11 irq_n", irq_n, (m_vec() == 8'h00));
            chk("R8 sleeping", sleeping, m_sleep);
        end
        quiet();
        summary();
        $finish;
    end
endmodule